// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns three serial audio data lines into parallel samples. All three lines share one bit clock and one frame clock, so each frame yields a left and a right sample per line: six channels in all. The bit clock runs the block directly. On every rising edge the block samples the frame clock and the three data lines. Data arrives most significant bit first, in two's complement.

A 2-bit format select picks the framing: right-justified, I2S or left-justified. The format also sets which frame-clock level marks the left channel. A 2-bit resolution select picks 24, 20, 18 or 16 significant bits. The block counts bit clocks between frame-clock transitions to find the slot width, 24 or 32 bits per channel. It accepts a new width only when two consecutive slots agree on it.

The capture controller is a two-state machine. In `CAP_WAIT` it waits for the slot bit position where the current format places the MSB. The *arm* transition moves it to `CAP_SHIFT`, which shifts one bit per clock. It returns to `CAP_WAIT` on one of two transitions:
- *complete*, when the last bit of the word has been shifted in;
- *abort*, on a frame-clock transition with the word unfinished, or when the format select becomes invalid.

A completed left word waits in a staging register. When the matching right word completes, all six outputs update together with a one-cycle frame-valid strobe.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset every output sample is zero and `frame_valid` is low.
- R2: With `fmt_sel` = 2'b10 (left-justified), a high frame clock marks the left channel. The MSB is the bit sampled on the first rising edge that sees the new frame-clock level.
- R3: With `fmt_sel` = 2'b01 (I2S), a low frame clock marks the left channel. The MSB is sampled one bit clock after the transition. With a 24-bit slot at 24-bit resolution, the LSB is the first bit of the following slot.
- R4: With `fmt_sel` = 2'b00 (right-justified), a high frame clock marks the left channel. Capture starts at slot position (slot width − resolution), so the LSB is the last bit before the next transition. Bits earlier in the slot have no effect on the sample.
- R5: `res_sel` selects 24 (2'b00), 20 (2'b01), 18 (2'b10) or 16 (2'b11) bits. A word narrower than 24 bits is placed with its MSB at bit 23, and the unused low bits are zero.
- R6: The slot width, 24 or 32 bit clocks, is found by counting bit clocks between frame-clock transitions. After reset the width is taken as 32.
- R7: A new slot width takes effect only after two consecutive slots both measure it. A single slot of a different length does not change how the following frame is decoded.
- R8: While `fmt_sel` = 2'b11 (invalid), all outputs hold their last values and `frame_valid` stays low.
- R9: `frame_valid` is a single-cycle pulse. It is raised once per frame, when a right word completes after a left word. All six outputs update on that same cycle.
- R10: Line k feeds `left_smp[k]` and `right_smp[k]`, independently of the other lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_clk | input | 1 | Frame (channel select) clock |
| sdata_in | input | NUM_LANES (3) | Serial data lines, one per stereo pair |
| fmt_sel | input | 2 | Framing: 00 right-justified, 01 I2S, 10 left-justified, 11 invalid |
| res_sel | input | 2 | Resolution: 00 24-bit, 01 20-bit, 10 18-bit, 11 16-bit |
| left_smp | output | NUM_LANES×SAMPLE_W (72) | Left samples, element k for line k |
| right_smp | output | NUM_LANES×SAMPLE_W (72) | Right samples, element k for line k |
| frame_valid | output | 1 | One-cycle strobe when a new frame is on the outputs |

## Verification
The bench aims at the places where the MSB or the LSB of a word sits against a frame-clock transition:
- **I2S, 24-bit slot, 24-bit word.** The LSB arrives on the first bit of the next slot. A controller that aborts on the transition before taking that bit would never publish a frame.
- **Right-justified mode.** The unused leading bits are driven high. A wrong start position would pull those ones into the sample or drop its LSB.
- **Word widths.** Each of the three shorter widths is run, so an alignment error would leave nonzero low bits.
- **A single short slot inside a 32-bit stream.** A width detector that adopted one measurement would move the right-justified start point and corrupt the next left sample.
- **Invalid format.** A stretch of frames is sent while the format is invalid. A receiver that kept decoding would change the outputs or pulse the strobe.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

    typedef enum logic [1:0] {
        FMT_RJ  = 2'b00,
        FMT_I2S = 2'b01,
        FMT_LJ  = 2'b10,
        FMT_BAD = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        WID_NONE  = 2'd0,
        WID_SHORT = 2'd1,
        WID_LONG  = 2'd2
    } wid_e;

    typedef enum logic {
        CAP_WAIT  = 1'b0,
        CAP_SHIFT = 1'b1
    } cap_e;

    // number of unused low bits for a resolution code (full word = 24)
    function automatic int unsigned res_drop(input logic [1:0] sel);
        unique case (sel)
            2'b00:   return 0;
            2'b01:   return 4;
            2'b10:   return 6;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/srx_slot_tracker.sv
module srx_slot_tracker
    import serial_audio_rx_pkg::*;
#(
    parameter int POS_W      = 6,
    parameter int SLOT_SHORT = 24,
    parameter int SLOT_LONG  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_clk,
    output logic             edge_o,
    output logic [POS_W-1:0] pos_o,
    output logic             synced_o,
    output logic             long_o
);

    localparam logic [POS_W-1:0] POS_MAX   = '1;
    localparam logic [POS_W:0]   LEN_SHORT = (POS_W+1)'(SLOT_SHORT);
    localparam logic [POS_W:0]   LEN_LONG  = (POS_W+1)'(SLOT_LONG);

    logic             fc_q;
    logic             seen_q;
    logic             synced_q;
    logic             long_q;
    logic [POS_W-1:0] cnt_q;
    wid_e             prev_w_q;
    wid_e             meas_w;
    logic [POS_W:0]   run_len;

    assign run_len = {1'b0, cnt_q} + (POS_W+1)'(1);

    always_comb begin
        edge_o = seen_q && (frame_clk != fc_q);
        if (run_len == LEN_SHORT)
            meas_w = WID_SHORT;
        else if (run_len == LEN_LONG)
            meas_w = WID_LONG;
        else
            meas_w = WID_NONE;
        if (edge_o)
            pos_o = '0;
        else if (cnt_q == POS_MAX)
            pos_o = cnt_q;
        else
            pos_o = cnt_q + POS_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fc_q     <= 1'b0;
            seen_q   <= 1'b0;
            synced_q <= 1'b0;
            long_q   <= 1'b1;
            cnt_q    <= '0;
            prev_w_q <= WID_NONE;
        end else begin
            fc_q   <= frame_clk;
            seen_q <= 1'b1;
            if (edge_o) begin
                cnt_q    <= '0;
                synced_q <= 1'b1;
                if (synced_q) begin
                    prev_w_q <= meas_w;
                    if (meas_w != WID_NONE && meas_w == prev_w_q)
                        long_q <= (meas_w == WID_LONG);
                end else begin
                    prev_w_q <= WID_NONE;
                end
            end else if (cnt_q != POS_MAX) begin
                cnt_q <= cnt_q + POS_W'(1);
            end
        end
    end

    assign synced_o = synced_q;
    assign long_o   = long_q;

    // a width switch must coincide with a slot that measured that width
    assert_width_agree_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(long_q) |-> ($past(run_len) == (long_q ? LEN_LONG : LEN_SHORT)));

endmodule

// File: rtl/srx_capture_ctrl.sv
module srx_capture_ctrl
    import serial_audio_rx_pkg::*;
#(
    parameter int SAMPLE_W   = 24,
    parameter int POS_W      = 6,
    parameter int SLOT_SHORT = 24,
    parameter int SLOT_LONG  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic [POS_W-1:0] pos_i,
    input  logic             synced_i,
    input  logic             long_i,
    input  logic             frame_clk,
    input  logic [1:0]       fmt_sel,
    input  logic [1:0]       res_sel,
    output logic             load_o,
    output logic             shift_o,
    output logic             finish_o,
    output logic             left_o
);

    fmt_e             fmt;
    cap_e             state_q;
    logic [POS_W-1:0] cnt_q;
    logic             left_q;
    logic [POS_W-1:0] res_p;
    logic [POS_W-1:0] slot_p;
    logic [POS_W-1:0] start_p;
    logic             fmt_ok;
    logic             start_hit;

    assign fmt    = fmt_e'(fmt_sel);
    assign fmt_ok = (fmt != FMT_BAD);
    assign res_p  = POS_W'(SAMPLE_W - int'(res_drop(res_sel)));
    assign slot_p = long_i ? POS_W'(SLOT_LONG) : POS_W'(SLOT_SHORT);

    always_comb begin
        unique case (fmt)
            FMT_RJ:  start_p = slot_p - res_p;
            FMT_I2S: start_p = POS_W'(1);
            FMT_LJ:  start_p = '0;
            FMT_BAD: start_p = '0;
        endcase
    end

    assign start_hit = synced_i && fmt_ok && (pos_i == start_p);

    // state register: arm / complete / abort
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CAP_WAIT;
            cnt_q   <= '0;
            left_q  <= 1'b0;
        end else begin
            unique case (state_q)
                CAP_WAIT: begin
                    if (start_hit) begin
                        state_q <= CAP_SHIFT;
                        cnt_q   <= POS_W'(1);
                        left_q  <= (fmt == FMT_I2S) ? !frame_clk : frame_clk;
                    end
                end
                CAP_SHIFT: begin
                    if (!fmt_ok)
                        state_q <= CAP_WAIT;
                    else if (cnt_q >= res_p - POS_W'(1))
                        state_q <= CAP_WAIT;
                    else if (edge_i)
                        state_q <= CAP_WAIT;
                    else
                        cnt_q <= cnt_q + POS_W'(1);
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        load_o   = 1'b0;
        shift_o  = 1'b0;
        finish_o = 1'b0;
        unique case (state_q)
            CAP_WAIT: load_o = start_hit;
            CAP_SHIFT: begin
                finish_o = fmt_ok && (cnt_q == res_p - POS_W'(1));
                shift_o  = fmt_ok && (finish_o || !edge_i);
            end
        endcase
    end

    assign left_o = left_q;

endmodule

// File: rtl/srx_lane.sv
module srx_lane #(
    parameter int SAMPLE_W = 24,
    parameter int DROP_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sdata_i,
    input  logic                load_i,
    input  logic                shift_i,
    input  logic                finish_i,
    input  logic                left_i,
    input  logic                publish_i,
    input  logic [DROP_W-1:0]   drop_i,
    output logic [SAMPLE_W-1:0] out_l,
    output logic [SAMPLE_W-1:0] out_r
);

    logic [SAMPLE_W-1:0] sr_q;
    logic [SAMPLE_W-1:0] stage_l_q;
    logic [SAMPLE_W-1:0] next_word;
    logic [SAMPLE_W-1:0] aligned;
    logic [SAMPLE_W-1:0] low_mask;

    assign next_word = {sr_q[SAMPLE_W-2:0], sdata_i};
    assign aligned   = next_word << drop_i;
    assign low_mask  = (SAMPLE_W'(1) << drop_i) - SAMPLE_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q      <= '0;
            stage_l_q <= '0;
            out_l     <= '0;
            out_r     <= '0;
        end else begin
            if (load_i)
                sr_q <= {{(SAMPLE_W-1){1'b0}}, sdata_i};
            else if (shift_i)
                sr_q <= next_word;
            if (finish_i && left_i)
                stage_l_q <= aligned;
            if (publish_i) begin
                out_l <= stage_l_q;
                out_r <= aligned;
            end
        end
    end

    // published right word carries zeros below the selected resolution
    assert_zero_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        publish_i |=> ((out_r & $past(low_mask)) == '0));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import serial_audio_rx_pkg::*;
#(
    parameter int NUM_LANES  = 3,
    parameter int SAMPLE_W   = 24,
    parameter int SLOT_SHORT = 24,
    parameter int SLOT_LONG  = 32
) (
    input  logic                                bit_clk,
    input  logic                                rst_n,
    input  logic                                frame_clk,
    input  logic [NUM_LANES-1:0]                sdata_in,
    input  logic [1:0]                          fmt_sel,
    input  logic [1:0]                          res_sel,
    output logic [NUM_LANES-1:0][SAMPLE_W-1:0]  left_smp,
    output logic [NUM_LANES-1:0][SAMPLE_W-1:0]  right_smp,
    output logic                                frame_valid
);

    localparam int POS_W  = $clog2(SLOT_LONG + 1) + 1;
    localparam int DROP_W = $clog2(SAMPLE_W);

    logic             edge_w;
    logic [POS_W-1:0] pos_w;
    logic             synced_w;
    logic             long_w;
    logic             load_w;
    logic             shift_w;
    logic             finish_w;
    logic             left_w;
    logic             left_ok_q;
    logic             publish;
    logic             fmt_ok;
    logic [DROP_W-1:0] drop_w;

    assign fmt_ok  = (fmt_e'(fmt_sel) != FMT_BAD);
    assign drop_w  = DROP_W'(res_drop(res_sel));
    assign publish = finish_w && !left_w && left_ok_q;

    srx_slot_tracker #(
        .POS_W(POS_W), .SLOT_SHORT(SLOT_SHORT), .SLOT_LONG(SLOT_LONG)
    ) u_track (
        .clk(bit_clk), .rst_n(rst_n), .frame_clk(frame_clk),
        .edge_o(edge_w), .pos_o(pos_w), .synced_o(synced_w), .long_o(long_w)
    );

    srx_capture_ctrl #(
        .SAMPLE_W(SAMPLE_W), .POS_W(POS_W),
        .SLOT_SHORT(SLOT_SHORT), .SLOT_LONG(SLOT_LONG)
    ) u_ctrl (
        .clk(bit_clk), .rst_n(rst_n), .edge_i(edge_w), .pos_i(pos_w),
        .synced_i(synced_w), .long_i(long_w), .frame_clk(frame_clk),
        .fmt_sel(fmt_sel), .res_sel(res_sel),
        .load_o(load_w), .shift_o(shift_w), .finish_o(finish_w), .left_o(left_w)
    );

    for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
        srx_lane #(.SAMPLE_W(SAMPLE_W), .DROP_W(DROP_W)) u_lane (
            .clk(bit_clk), .rst_n(rst_n), .sdata_i(sdata_in[k]),
            .load_i(load_w), .shift_i(shift_w), .finish_i(finish_w),
            .left_i(left_w), .publish_i(publish), .drop_i(drop_w),
            .out_l(left_smp[k]), .out_r(right_smp[k])
        );
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            left_ok_q   <= 1'b0;
            frame_valid <= 1'b0;
        end else begin
            frame_valid <= publish;
            if (!fmt_ok)
                left_ok_q <= 1'b0;
            else if (finish_w && left_w)
                left_ok_q <= 1'b1;
            else if (publish)
                left_ok_q <= 1'b0;
        end
    end

    assert_strobe_single_R9: assert property (@(posedge bit_clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    assert_strobe_after_left_R9: assert property (@(posedge bit_clk) disable iff (!rst_n)
        frame_valid |-> $past(left_ok_q));

    assert_no_strobe_invalid_R8: assert property (@(posedge bit_clk) disable iff (!rst_n)
        frame_valid |-> ($past(fmt_sel) != 2'b11));

    assert_hold_invalid_R8: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (fmt_sel == 2'b11) |=> ($stable(left_smp) && $stable(right_smp)));

endmodule

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;

    localparam int LANES = 3;
    localparam int W     = 24;
    typedef logic [LANES-1:0][W-1:0] trip_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fclk = 1'b1;
    logic [LANES-1:0] sd = '0;
    logic [1:0]   fmt = 2'b10;
    logic [1:0]   rsel = 2'b00;
    trip_t        lo, ro;
    logic         fv;

    int    checks = 0;
    int    fails = 0;
    int    strobes = 0;
    string tag = "R1";
    trip_t qL[$];
    trip_t qR[$];
    trip_t mon_el, mon_er;
    logic  prev_fv = 1'b0;
    logic  carry_on = 1'b0;
    logic [LANES-1:0] carry_b = '0;

    always #4 clk = ~clk;

    serial_audio_rx u_dut (
        .bit_clk(clk), .rst_n(rst_n), .frame_clk(fclk), .sdata_in(sd),
        .fmt_sel(fmt), .res_sel(rsel), .left_smp(lo), .right_smp(ro),
        .frame_valid(fv)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // strobe monitor: compares published frames against expected queue
    always @(negedge clk) begin
        if (rst_n && fv) begin
            strobes++;
            if (prev_fv)
                check(1'b0, "R9", "strobe longer than one cycle", 2, 1);
            if (qL.size() > 0) begin
                mon_el = qL.pop_front();
                mon_er = qR.pop_front();
                check(lo == mon_el, tag, "left samples (R10)", lo, mon_el);
                check(ro == mon_er, tag, "right samples (R10)", ro, mon_er);
            end
        end
        prev_fv = fv;
    end

    function automatic int res_of(input logic [1:0] s);
        case (s)
            2'b00:   return 24;
            2'b01:   return 20;
            2'b10:   return 18;
            default: return 16;
        endcase
    endfunction

    function automatic logic [W-1:0] keep_mask(input int res);
        return ~((W'(1) << (W - res)) - W'(1));
    endfunction

    // bit at slot position p; positions outside the word carry a 1
    function automatic logic gen_bit(input logic [1:0] m, input int res, input int slot,
                                     input int p, input logic [W-1:0] s);
        int start;
        case (m)
            2'b00:   start = slot - res;
            2'b01:   start = 1;
            default: start = 0;
        endcase
        if (p >= start && p < start + res)
            return s[W-1-(p-start)];
        return 1'b1;
    endfunction

    function automatic trip_t mk(input int k, input int side);
        trip_t t;
        for (int i = 0; i < LANES; i++)
            t[i] = W'(32'h00A5_3C17 * (k*2 + side + 1) + i * 32'h0093_579B + k * 32'h0080_0001);
        return t;
    endfunction

    task automatic send_half(input logic lvl, input int slot, input trip_t s,
                             input bit push_now, input trip_t pl, input trip_t pr);
        int res = res_of(rsel);
        for (int p = 0; p < slot; p++) begin
            @(negedge clk);
            fclk = lvl;
            for (int i = 0; i < LANES; i++)
                sd[i] = (p == 0 && carry_on) ? carry_b[i] : gen_bit(fmt, res, slot, p, s[i]);
            if (p == 4 && push_now) begin
                qL.push_back(pl);
                qR.push_back(pr);
            end
        end
        carry_on = (fmt == 2'b01) && (res + 1 > slot);
        for (int i = 0; i < LANES; i++)
            carry_b[i] = s[i][W-res];
    endtask

    task automatic send_frame(input int lslot, input int rslot,
                              input trip_t L, input trip_t R, input bit push);
        logic  lv;
        trip_t eL, eR;
        lv = (fmt == 2'b01) ? 1'b0 : 1'b1;
        for (int i = 0; i < LANES; i++) begin
            eL[i] = L[i] & keep_mask(res_of(rsel));
            eR[i] = R[i] & keep_mask(res_of(rsel));
        end
        send_half(lv, lslot, L, push, eL, eR);
        send_half(!lv, rslot, R, 1'b0, eL, eR);
    endtask

    task automatic run_case(input logic [1:0] m, input logic [1:0] rs,
                            input int slot, input string t);
        fmt = m;
        rsel = rs;
        tag = t;
        repeat (3) send_frame(slot, slot, '0, '0, 1'b0);
        for (int k = 0; k < 3; k++)
            send_frame(slot, slot, mk(k, 0), mk(k, 1), 1'b1);
        send_frame(slot, slot, '0, '0, 1'b0);
        repeat (4) @(negedge clk);
        check(qL.size() == 0, {t, " R9"}, "frames not all published", qL.size(), 0);
        qL.delete();
        qR.delete();
    endtask

    // R8: invalid format holds outputs, no strobe
    task automatic run_invalid();
        trip_t snapL, snapR;
        int    s0;
        snapL = lo;
        snapR = ro;
        s0 = strobes;
        fmt = 2'b11;
        tag = "R8";
        for (int k = 0; k < 3; k++)
            send_frame(32, 32, mk(k + 5, 0), mk(k + 5, 1), 1'b0);
        repeat (4) @(negedge clk);
        check(strobes == s0, "R8", "strobe count in invalid format", strobes, s0);
        check(lo == snapL, "R8", "left held", lo, snapL);
        check(ro == snapR, "R8", "right held", ro, snapR);
    endtask

    // R7: one short slot must not move the right-justified start point
    task automatic run_glitch();
        fmt = 2'b00;
        rsel = 2'b11;
        tag = "R7";
        repeat (3) send_frame(32, 32, '0, '0, 1'b0);
        send_frame(32, 32, mk(9, 0), mk(9, 1), 1'b1);
        send_frame(32, 24, mk(10, 0), mk(10, 1), 1'b0);
        send_frame(32, 32, mk(11, 0), mk(11, 1), 1'b1);
        send_frame(32, 32, '0, '0, 1'b0);
        repeat (4) @(negedge clk);
        check(qL.size() == 0, "R7", "frames not all published", qL.size(), 0);
        qL.delete();
        qR.delete();
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(lo == '0, "R1", "left after reset", lo, 0);
        check(ro == '0, "R1", "right after reset", ro, 0);
        check(fv == 1'b0, "R1", "strobe after reset", fv, 0);

        run_case(2'b10, 2'b00, 32, "R2 R6");
        run_case(2'b01, 2'b00, 32, "R3");
        run_case(2'b00, 2'b11, 32, "R4 R5");
        run_case(2'b10, 2'b01, 24, "R2 R5 R6");
        run_case(2'b01, 2'b00, 24, "R3 R6");
        run_case(2'b00, 2'b10, 24, "R4 R5 R6");
        run_invalid();
        run_case(2'b10, 2'b00, 32, "R8 recovery R10");
        run_glitch();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule